// File: doc/BRIEF.md
# Multiplexed ADC Scan Sequencer

This block sequences the input selection of a multichannel oversampling converter. For each conversion slot it presents a channel code, a channel ID tag and the index of the transfer-function register whose settings govern that conversion. A one-cycle conversion-done strobe from the filter model moves it along. The mode pair, the differential flag, the scan flag and the two address bits choose the sequence. Calibration modes add a calibration-offset slot and a calibration-gain slot to the end of the scan.

An active-low ready flag reports when filtered data is valid. Certain events restart the filter: a control write aimed at the register that is currently in use, or any change to the mode, differential, scan or address inputs. On a restart the block raises the ready flag at once and pulses a filter reset. The flag stays high until a parameterised number of conversions has passed. A control write to a register that is not in use leaves everything unchanged. The reserved mode holds the block idle.

Top module: `scan_sequencer`

## Requirements
- R1: After a synchronous reset the block is in slot 0 with `int_n` high and `filt_rst` low.
- R2: In scan mode with mode 00 and `diff`=1, the channel codes run 0 (AIN1/AIN2), 1 (AIN3/AIN4), 2 (AIN5/AIN6) and then wrap to 0. The registers are 1, 2, 3 and the tags are 0, 1, 2.
- R3: In scan mode with mode 00 and `diff`=0, the channel codes run 3..7 (AIN1..AIN5 each measured against AIN6) and then wrap. The registers are 1, 1, 2, 2, 3 and the tags are 0..4.
- R4: In scan mode with mode 01 or 10, the normal sequence is followed by code 8 (calibration offset) and then code 9 (calibration gain). Both of these slots use register 3 and carry the same tag, which is 3 when `diff`=1 and 5 when `diff`=0.
- R5: With `scan`=0 the slot never advances. Mode 00 with `diff`=1 selects pair code `addr` (an `addr` of 3 gives 2), and its register is the code plus 1. Mode 00 with `diff`=0 selects code 3+`addr`, with register 1 for `addr` below 2 and register 2 otherwise. Mode 01 selects code 8 and mode 10 selects code 9, each with register `addr`+1, limited to 3. The tag is 0.
- R6: After a restart, `int_n` falls on the edge that samples the SETTLE-th conversion strobe (default 3). Strobes that arrive before that point do not advance the slot. Once `int_n` is low, each strobe advances the slot by one.
- R7: A control write (`ctl_wr` with `ctl_sel` equal to `reg_idx`) sets `int_n` high and produces a one-cycle `filt_rst` pulse on the next edge. The slot is kept.
- R8: A control write to any other register leaves `int_n`, `filt_rst` and the scan unchanged.
- R9: Mode 11 is illegal. While it is applied, `chan` is 15, `reg_idx` is 0, `int_n` stays high and conversion strobes have no effect.
- R10: Any change of `mode`, `diff`, `scan` or `addr` restarts the block: slot 0, `int_n` high and a `filt_rst` pulse on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 normal, 01 offset cal, 10 gain cal, 11 illegal |
| diff | input | 1 | 1 = differential pairs, 0 = single-ended against AIN6 |
| scan | input | 1 | 1 = step through the sequence |
| addr | input | 2 | Channel/register address when not scanning |
| ctl_wr | input | 1 | Strobe marking a control-register write |
| ctl_sel | input | 2 | Register (1..3) targeted by the write |
| conv_done | input | 1 | Conversion-complete strobe from the filter |
| chan | output | 4 | Current channel code |
| tag | output | 3 | Channel ID tag |
| reg_idx | output | 2 | Transfer-function register in use (0 = none) |
| filt_rst | output | 1 | One-cycle modulator/filter reset pulse |
| int_n | output | 1 | Active-low data-ready flag |

## Verification
A corrupted slot counter shows up on `chan`, `tag` and `reg_idx` as soon as the next strobe arrives, as a skipped, repeated or unwrapped code. The bench therefore walks every sequence past its wrap point. A wrong settle count or restart decision shows on `int_n` one edge after the triggering strobe or write. For that reason the flag is sampled after each single strobe during settling and directly after each control write.

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int SETTLE = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       diff,
  input  logic       scan,
  input  logic [1:0] addr,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_sel,
  input  logic       conv_done,
  output logic [3:0] chan,
  output logic [2:0] tag,
  output logic [1:0] reg_idx,
  output logic       filt_rst,
  output logic       int_n
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [2:0]    slot;
  logic [CW-1:0] cnt;
  logic [5:0]    cfg_q;

  wire       illegal = (mode == 2'b11);
  wire       cal     = (mode == 2'b01) || (mode == 2'b10);
  wire [2:0] base    = diff ? 3'd3 : 3'd5;
  wire [2:0] len     = base + (cal ? 3'd2 : 3'd0);
  wire [5:0] cfg     = {mode, diff, scan, addr};
  wire       cfg_chg = (cfg != cfg_q);
  wire       restart = cfg_chg || (ctl_wr && !illegal && ctl_sel == reg_idx);
  wire [1:0] addr_reg = (addr == 2'd3) ? 2'd3 : addr + 2'd1;

  always_comb begin
    chan = 4'd15;
    tag = 3'd0;
    reg_idx = 2'd0;
    if (!illegal) begin
      if (scan) begin
        tag = slot;
        if (slot < base) begin
          if (diff) begin
            chan = {2'b00, slot[1:0]};
            reg_idx = slot[1:0] + 2'd1;
          end else begin
            chan = 4'd3 + {1'b0, slot};
            reg_idx = (slot < 3'd2) ? 2'd1 : (slot < 3'd4) ? 2'd2 : 2'd3;
          end
        end else if (cal && slot == base) begin
          chan = 4'd8;
          reg_idx = 2'd3;
        end else if (cal && slot == base + 3'd1) begin
          chan = 4'd9;
          tag = base;
          reg_idx = 2'd3;
        end else begin
          tag = 3'd0;
        end
      end else if (mode == 2'b00) begin
        if (diff) begin
          chan = (addr == 2'd3) ? 4'd2 : {2'b00, addr};
          reg_idx = addr_reg;
        end else begin
          chan = 4'd3 + {2'b00, addr};
          reg_idx = addr[1] ? 2'd2 : 2'd1;
        end
      end else begin
        chan = mode[0] ? 4'd8 : 4'd9;
        reg_idx = addr_reg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= 3'd0;
      cnt <= '0;
      int_n <= 1'b1;
      filt_rst <= 1'b0;
      cfg_q <= cfg;
    end else begin
      cfg_q <= cfg;
      filt_rst <= restart;
      if (restart) begin
        int_n <= 1'b1;
        cnt <= '0;
        if (cfg_chg) slot <= 3'd0;
      end else if (illegal) begin
        int_n <= 1'b1;
        cnt <= '0;
        slot <= 3'd0;
      end else if (conv_done) begin
        if (int_n) begin
          if (cnt == CW'(SETTLE - 1)) int_n <= 1'b0;
          else cnt <= cnt + 1'b1;
        end else if (scan) begin
          slot <= (slot >= len - 3'd1) ? 3'd0 : slot + 3'd1;
        end
      end
    end
  end

  assert_rst_hides_data_R7: assert property (@(posedge clk) disable iff (rst)
    filt_rst |-> int_n);
  assert_illegal_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> int_n);
  assert_ready_on_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(int_n) |-> $past(conv_done));
  assert_scan_has_reg_R2: assert property (@(posedge clk) disable iff (rst)
    (scan && mode != 2'b11) |-> reg_idx != 2'd0);
  assert_cal_reg3_R4: assert property (@(posedge clk) disable iff (rst)
    (scan && chan >= 4'd8 && chan <= 4'd9) |-> reg_idx == 2'd3);
endmodule

// File: tb/scan_sequencer_test.sv
module scan_sequencer_test;
  logic clk = 0, rst = 1;
  logic [1:0] mode = 0, addr = 0, ctl_sel = 0;
  logic diff = 1, scan = 1, ctl_wr = 0, conv_done = 0;
  logic [3:0] chan;
  logic [2:0] tag;
  logic [1:0] reg_idx;
  logic filt_rst, int_n;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  scan_sequencer uut (.clk, .rst, .mode, .diff, .scan, .addr, .ctl_wr,
    .ctl_sel, .conv_done, .chan, .tag, .reg_idx, .filt_rst, .int_n);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic strobe();
    conv_done = 1; tick(); conv_done = 0;
  endtask

  task automatic do_reset(input logic [1:0] m, input logic d, input logic s, input logic [1:0] a);
    mode = m; diff = d; scan = s; addr = a; rst = 1;
    tick(); tick(); rst = 0; tick();
  endtask

  task automatic settle();
    for (int i = 0; i < 3; i++) strobe();
  endtask

  task automatic t_reset();
    do_reset(2'b00, 1, 1, 0);
    chk("R1 chan", chan, 0); chk("R1 int_n", int_n, 1); chk("R1 filt_rst", filt_rst, 0);
  endtask

  task automatic t_settle();
    do_reset(2'b00, 1, 1, 0);
    strobe(); strobe();
    chk("R6 int_n before settle", int_n, 1); chk("R6 no advance", chan, 0);
    strobe();
    chk("R6 int_n settled", int_n, 0); chk("R6 chan kept", chan, 0);
  endtask

  task automatic t_diff();
    do_reset(2'b00, 1, 1, 0); settle();
    for (int i = 0; i < 4; i++) begin
      chk("R2 chan", chan, i % 3); chk("R2 reg", reg_idx, i % 3 + 1); chk("R2 tag", tag, i % 3);
      strobe();
    end
  endtask

  task automatic t_single();
    int regs[5] = '{1, 1, 2, 2, 3};
    do_reset(2'b00, 0, 1, 0); settle();
    for (int i = 0; i < 6; i++) begin
      chk("R3 chan", chan, 3 + i % 5); chk("R3 reg", reg_idx, regs[i % 5]); chk("R3 tag", tag, i % 5);
      strobe();
    end
  endtask

  task automatic t_cal();
    do_reset(2'b01, 1, 1, 0); settle();
    for (int i = 0; i < 3; i++) strobe();
    chk("R4 caloff chan", chan, 8); chk("R4 caloff reg", reg_idx, 3); chk("R4 caloff tag", tag, 3);
    strobe();
    chk("R4 calgain chan", chan, 9); chk("R4 calgain reg", reg_idx, 3); chk("R4 calgain tag", tag, 3);
    strobe();
    chk("R4 wrap", chan, 0);
    do_reset(2'b10, 0, 1, 0); settle();
    for (int i = 0; i < 5; i++) strobe();
    chk("R4 se caloff", chan, 8); chk("R4 se tag", tag, 5);
    strobe();
    chk("R4 se calgain", chan, 9); chk("R4 se gain tag", tag, 5);
  endtask

  task automatic t_nonscan();
    do_reset(2'b00, 1, 0, 1); settle();
    chk("R5 pair chan", chan, 1); chk("R5 pair reg", reg_idx, 2); chk("R5 tag", tag, 0);
    strobe(); strobe();
    chk("R5 no advance", chan, 1);
    do_reset(2'b00, 0, 0, 2);
    chk("R5 se chan", chan, 5); chk("R5 se reg", reg_idx, 2);
    do_reset(2'b01, 1, 0, 1);
    chk("R5 caloff chan", chan, 8); chk("R5 caloff reg", reg_idx, 2);
    do_reset(2'b10, 1, 0, 3);
    chk("R5 calgain chan", chan, 9); chk("R5 calgain reg", reg_idx, 3);
  endtask

  task automatic t_write();
    do_reset(2'b00, 1, 1, 0); settle(); strobe();
    chk("R7 at slot1", chan, 1);
    ctl_wr = 1; ctl_sel = 2; tick(); ctl_wr = 0;
    chk("R7 int_n high", int_n, 1); chk("R7 filt_rst", filt_rst, 1); chk("R7 slot kept", chan, 1);
    tick();
    chk("R7 pulse ends", filt_rst, 0);
    settle();
    ctl_wr = 1; ctl_sel = 1; tick(); ctl_wr = 0;
    chk("R8 int_n", int_n, 0); chk("R8 filt_rst", filt_rst, 0);
    strobe();
    chk("R8 still advances", chan, 2);
  endtask

  task automatic t_illegal();
    do_reset(2'b00, 1, 1, 0); settle();
    mode = 2'b11; tick();
    chk("R9 chan", chan, 15); chk("R9 reg", reg_idx, 0); chk("R9 int_n", int_n, 1);
    for (int i = 0; i < 4; i++) strobe();
    chk("R9 int_n held", int_n, 1);
  endtask

  task automatic t_cfgchg();
    do_reset(2'b00, 1, 1, 0); settle(); strobe(); strobe();
    chk("R10 at slot2", chan, 2);
    addr = 2; tick();
    chk("R10 int_n", int_n, 1); chk("R10 filt_rst", filt_rst, 1); chk("R10 slot0", chan, 0);
  endtask

  initial begin
    tick();
    t_reset(); t_settle(); t_diff(); t_single(); t_cal();
    t_nonscan(); t_write(); t_illegal(); t_cfgchg();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule